// File: doc/BRIEF.md
# Keyhole configuration packet router

This block sits behind a small write-only window. Software writes 32-bit words into it, and the block assembles them into 128-bit quadword packets. The word-select address bits pick one of four slots. A write to the last slot completes the packet: the block takes a snapshot of all four words and empties the gather buffer.

Each completed packet is handled in one of two modes.
- In header mode, the block decodes the first word. A frame-type header sends the remaining three words to one configuration-frame row, or to every row when the broadcast row code is used. A bulk-setup header loads a quadword count and latches a target row.
- In bulk mode, the count is nonzero. Each following quadword goes unchanged to the latched row as bulk-data register traffic, and the count drops by one.

While the decompression-enable input is high, completed packets are dropped.

All rows share one register-address bus and one 128-bit data bus. Each row has its own one-cycle valid strobe. The remaining quadword count is visible on an output port. Two sticky error flags report a count that is not a multiple of the frame size and a packet aimed at a row that does not exist.

Top module: `keyhole_router`

## Requirements
- R1: The slot of a write is set by `wr_addr[3:2]`, and writes may arrive in any slot order. A write to slot 3 completes the packet. The resulting delivery appears on the outputs in the cycle after that write and lasts exactly one cycle.
- R2: A completed packet empties the gather buffer. Any slot not written before the next completion reads as zero.
- R3: Word 0 of a packet holds the header fields: type in bits [31:24], row in bits [20:16], register address in bits [13:8].
- R4: With the count at zero, a packet of type `TYPE_FRAME` (default 0x00) is delivered to the decoded row with the decoded register address. The data bus carries word 1 in [31:0], word 2 in [63:32], word 3 in [95:64] and zero in [127:96].
- R5: With the count at zero, a packet of type `TYPE_BULK` (default 0x80) with register address `BULK_REG` (default 2) loads word 1 into the count and latches the header row. Nothing is delivered.
- R6: While the count is nonzero, every completed packet is delivered whole (word 0 in [31:0] up to word 3 in [127:96]). It goes to the latched row with register address `BULK_REG`, whatever its header says, and the count decrements by one. Once the count reaches zero, header mode resumes.
- R7: A loaded count that is not a multiple of `FRAME_QW` (default 25) sets the sticky `cnt_err`. The load still takes effect.
- R8: Row code 31 delivers to all `NUM_ROWS` (default 15) row ports at once.
- R9: A non-broadcast row of `NUM_ROWS` or more (15 to 30 by default) is not delivered anywhere and sets the sticky `row_err`.
- R10: While `decomp_en` is high, completed packets produce no delivery and leave the count unchanged.
- R11: After reset, no valid strobe is set, the count and both error flags are zero, and the gather buffer holds zeros.
- R12: With the count at zero, a packet whose type matches neither code is ignored. There is no delivery and the count stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe into the window |
| wr_addr | input | 2 (bits [3:2]) | Word-select address bits; they choose the slot |
| wr_data | input | 32 | Write data |
| decomp_en | input | 1 | Decompression enable; drops completed packets while high |
| row_valid | output | NUM_ROWS | One-cycle delivery strobe, one bit per row |
| row_reg | output | 6 | Target register address of the delivered packet |
| row_data | output | 128 | Delivered packet data |
| frame_cnt | output | 32 | Remaining bulk quadword count |
| cnt_err | output | 1 | Sticky: a loaded count was not a multiple of FRAME_QW |
| row_err | output | 1 | Sticky: a packet targeted a non-existent row |

## Verification
The slot-3 write is the only stimulus that has an effect beyond the buffer. Its results — the valid strobe, the register address and data, the count and both error flags — all come from the same register stage, so they are due exactly one clock edge after that write. The bench drives every write at a falling edge and returns from the write task at the next falling edge, just after the result edge. All outputs are checked at that point. One more falling edge later, the bench confirms that the strobe has dropped again. For cases where nothing should be delivered, the strobe, count and flags are sampled at that same falling edge.

// File: rtl/kr_pkg.sv
`timescale 1ns/1ps
package kr_pkg;
  typedef logic [31:0] word_t;

  // w0 sits in the least significant bits
  typedef struct packed {
    word_t w3;
    word_t w2;
    word_t w1;
    word_t w0;
  } quad_t;

  localparam logic [4:0] BCAST_ROW = 5'h1F;
endpackage

// File: rtl/kr_gather.sv
`timescale 1ns/1ps
module kr_gather
  import kr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:2]  wr_addr,
  input  word_t       wr_data,
  output logic        done,
  output quad_t       pkt
);
  localparam int SLOTS = 4;

  word_t words_q [SLOTS-1];
  word_t words_d [SLOTS-1];

  assign done = wr_en && (wr_addr == 2'd3);
  assign pkt  = '{w3: wr_data, w2: words_q[2], w1: words_q[1], w0: words_q[0]};

  always_comb begin
    for (int i = 0; i < SLOTS-1; i++) words_d[i] = words_q[i];
    if (done) begin
      for (int i = 0; i < SLOTS-1; i++) words_d[i] = '0;
    end else if (wr_en) begin
      words_d[wr_addr] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS-1; i++) words_q[i] <= '0;
    end else begin
      for (int i = 0; i < SLOTS-1; i++) words_q[i] <= words_d[i];
    end
  end

  // R2: buffer is empty right after a completion
  p_buf_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (words_q[0] == '0 && words_q[1] == '0 && words_q[2] == '0));
endmodule

// File: rtl/kr_decode.sv
`timescale 1ns/1ps
module kr_decode
  import kr_pkg::*;
#(
  parameter int          NUM_ROWS   = 15,
  parameter logic [7:0]  TYPE_FRAME = 8'h00,
  parameter logic [7:0]  TYPE_BULK  = 8'h80,
  parameter logic [5:0]  BULK_REG   = 6'h02,
  parameter int          FRAME_QW   = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        done,
  input  quad_t       pkt,
  input  logic        decomp_en,
  output logic        fire_q,
  output logic [4:0]  out_row_q,
  output logic [5:0]  out_reg_q,
  output quad_t       out_data_q,
  output word_t       cnt_q,
  output logic        cnt_err_q,
  output logic        row_err_q
);
  localparam logic [4:0] ROW_LIM = 5'(NUM_ROWS);
  localparam word_t      QW_DIV  = 32'(FRAME_QW);

  logic [7:0] hdr_type;
  logic [4:0] hdr_row;
  logic [5:0] hdr_reg;
  logic [4:0] tgt_q, tgt_d;
  word_t      cnt_d;
  logic       cnt_err_d, row_err_d, fire_d;
  logic [4:0] out_row_d;
  logic [5:0] out_reg_d;
  quad_t      out_data_d;
  logic       send;
  logic [4:0] s_row;
  logic [5:0] s_reg;
  quad_t      s_data;

  assign hdr_type = pkt.w0[31:24];
  assign hdr_row  = pkt.w0[20:16];
  assign hdr_reg  = pkt.w0[13:8];

  always_comb begin
    cnt_d      = cnt_q;
    tgt_d      = tgt_q;
    cnt_err_d  = cnt_err_q;
    row_err_d  = row_err_q;
    fire_d     = 1'b0;
    out_row_d  = out_row_q;
    out_reg_d  = out_reg_q;
    out_data_d = out_data_q;
    send       = 1'b0;
    s_row      = tgt_q;
    s_reg      = BULK_REG;
    s_data     = pkt;
    if (done && !decomp_en) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 32'd1;
        send  = 1'b1;
      end else if (hdr_type == TYPE_BULK && hdr_reg == BULK_REG) begin
        cnt_d = pkt.w1;
        tgt_d = hdr_row;
        if ((pkt.w1 % QW_DIV) != '0) cnt_err_d = 1'b1;
      end else if (hdr_type == TYPE_FRAME) begin
        send   = 1'b1;
        s_row  = hdr_row;
        s_reg  = hdr_reg;
        s_data = '{w3: '0, w2: pkt.w3, w1: pkt.w2, w0: pkt.w1};
      end
    end
    if (send) begin
      if (s_row == BCAST_ROW || s_row < ROW_LIM) begin
        fire_d     = 1'b1;
        out_row_d  = s_row;
        out_reg_d  = s_reg;
        out_data_d = s_data;
      end else begin
        row_err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      tgt_q      <= '0;
      cnt_err_q  <= 1'b0;
      row_err_q  <= 1'b0;
      fire_q     <= 1'b0;
      out_row_q  <= '0;
      out_reg_q  <= '0;
      out_data_q <= '0;
    end else begin
      cnt_q      <= cnt_d;
      tgt_q      <= tgt_d;
      cnt_err_q  <= cnt_err_d;
      row_err_q  <= row_err_d;
      fire_q     <= fire_d;
      out_row_q  <= out_row_d;
      out_reg_q  <= out_reg_d;
      out_data_q <= out_data_d;
    end
  end

  // R6: each bulk packet consumes one count
  p_bulk_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !decomp_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 32'd1));
  // R10: dropped packets leave no trace
  p_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && decomp_en) |=> (!fire_q && $stable(cnt_q)));
  // R9: a delivery never names a missing row; error flag sticks
  p_fire_row_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> (out_row_q == BCAST_ROW || out_row_q < ROW_LIM));
  p_row_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    row_err_q |=> row_err_q);
  // R7: count error sticks
  p_cnt_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err_q |=> cnt_err_q);
  // R1: a delivery lasts one cycle without a new completion
  p_one_shot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_q && !done) |=> !fire_q);
endmodule

// File: rtl/kr_fanout.sv
`timescale 1ns/1ps
module kr_fanout
  import kr_pkg::*;
#(
  parameter int NUM_ROWS = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic [4:0]          row,
  output logic [NUM_ROWS-1:0] valid
);
  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
    assign valid[g] = fire && (row == BCAST_ROW || row == 5'(g));
  end

  // R8: a partial set of strobes is always a single row
  p_single_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid != '0 && !(&valid)) |-> $onehot0(valid));
endmodule

// File: rtl/keyhole_router.sv
`timescale 1ns/1ps
module keyhole_router
  import kr_pkg::*;
#(
  parameter int          NUM_ROWS   = 15,
  parameter logic [7:0]  TYPE_FRAME = 8'h00,
  parameter logic [7:0]  TYPE_BULK  = 8'h80,
  parameter logic [5:0]  BULK_REG   = 6'h02,
  parameter int          FRAME_QW   = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [3:2]          wr_addr,
  input  logic [31:0]         wr_data,
  input  logic                decomp_en,
  output logic [NUM_ROWS-1:0] row_valid,
  output logic [5:0]          row_reg,
  output logic [127:0]        row_data,
  output logic [31:0]         frame_cnt,
  output logic                cnt_err,
  output logic                row_err
);
  logic       done;
  quad_t      pkt;
  logic       fire;
  logic [4:0] out_row;
  quad_t      out_data;

  kr_gather u_gather (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .pkt(pkt)
  );

  kr_decode #(
    .NUM_ROWS(NUM_ROWS), .TYPE_FRAME(TYPE_FRAME), .TYPE_BULK(TYPE_BULK),
    .BULK_REG(BULK_REG), .FRAME_QW(FRAME_QW)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .done(done), .pkt(pkt), .decomp_en(decomp_en),
    .fire_q(fire), .out_row_q(out_row), .out_reg_q(row_reg),
    .out_data_q(out_data), .cnt_q(frame_cnt), .cnt_err_q(cnt_err),
    .row_err_q(row_err)
  );

  kr_fanout #(.NUM_ROWS(NUM_ROWS)) u_fanout (
    .clk(clk), .rst_n(rst_n), .fire(fire), .row(out_row), .valid(row_valid)
  );

  assign row_data = out_data;
endmodule

// File: tb/test_keyhole_router.sv
`timescale 1ns/1ps
module test_keyhole_router;
  localparam int NR = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [3:2]    wr_addr;
  logic [31:0]   wr_data;
  logic          decomp_en;
  logic [NR-1:0] row_valid;
  logic [5:0]    row_reg;
  logic [127:0]  row_data;
  logic [31:0]   frame_cnt;
  logic          cnt_err;
  logic          row_err;

  int nvec  = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  keyhole_router i_keyhole_router (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .decomp_en(decomp_en), .row_valid(row_valid),
    .row_reg(row_reg), .row_data(row_data), .frame_cnt(frame_cnt),
    .cnt_err(cnt_err), .row_err(row_err)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [7:0] t, input logic [4:0] r,
                                      input logic [5:0] g);
    return {t, 3'b000, r, 2'b00, g, 8'h00};
  endfunction

  // drive at a falling edge, return at the next falling edge
  task automatic put(input int slot, input logic [31:0] d);
    wr_en   = 1'b1;
    wr_addr = 2'(slot);
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic send(input logic [31:0] w0, input logic [31:0] w1,
                      input logic [31:0] w2, input logic [31:0] w3);
    put(0, w0); put(1, w1); put(2, w2); put(3, w3);
  endtask

  task automatic t_reset;
    chk(row_valid == '0, "R11 valid", 128'(row_valid), 0);
    chk(frame_cnt == '0, "R11 count", 128'(frame_cnt), 0);
    chk({cnt_err, row_err} == 2'b00, "R11 flags", 128'({cnt_err, row_err}), 0);
    put(3, 32'hCAFE_0003);  // empty buffer: header reads as frame, row 0, reg 0
    chk(row_valid == NR'(1), "R11 empty buffer row", 128'(row_valid), 1);
    chk(row_data == {32'h0, 32'hCAFE_0003, 64'h0}, "R11 empty buffer data",
        row_data, {32'h0, 32'hCAFE_0003, 64'h0});
    @(negedge clk);
  endtask

  task automatic t_frame;
    put(2, 32'h2222_2222); put(0, hdr(8'h00, 5'd5, 6'h11)); put(1, 32'h1111_1111);
    put(3, 32'h3333_3333);
    chk(row_valid == NR'(1 << 5), "R1 R3 row strobe", 128'(row_valid), 128'(1 << 5));
    chk(row_reg == 6'h11, "R3 register", 128'(row_reg), 128'h11);
    chk(row_data == {32'h0, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111},
        "R4 data layout", row_data,
        {32'h0, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111});
    @(negedge clk);
    chk(row_valid == '0, "R1 one cycle", 128'(row_valid), 0);
  endtask

  task automatic t_clear;
    send(hdr(8'h00, 5'd1, 6'h01), 32'hAAAA_0001, 32'hAAAA_0002, 32'hAAAA_0003);
    @(negedge clk);
    put(0, hdr(8'h00, 5'd7, 6'h04)); put(3, 32'hBBBB_0003);
    chk(row_valid == NR'(1 << 7), "R2 row", 128'(row_valid), 128'(1 << 7));
    chk(row_data == {32'h0, 32'hBBBB_0003, 64'h0}, "R2 stale slots zero",
        row_data, {32'h0, 32'hBBBB_0003, 64'h0});
    @(negedge clk);
  endtask

  task automatic t_bcast;
    send(hdr(8'h00, 5'd31, 6'h09), 32'h1, 32'h2, 32'h3);
    chk(row_valid == {NR{1'b1}}, "R8 broadcast", 128'(row_valid), 128'({NR{1'b1}}));
    chk(row_reg == 6'h09, "R8 register", 128'(row_reg), 128'h09);
    @(negedge clk);
  endtask

  task automatic t_other;
    send(hdr(8'h40, 5'd2, 6'h02), 32'd50, 32'h0, 32'h0);
    chk(row_valid == '0, "R12 no delivery", 128'(row_valid), 0);
    chk(frame_cnt == '0, "R12 count", 128'(frame_cnt), 0);
    @(negedge clk);
  endtask

  task automatic t_badrow;
    chk(row_err == 1'b0, "R9 flag clear before", 128'(row_err), 0);
    send(hdr(8'h00, 5'd20, 6'h01), 32'h5, 32'h6, 32'h7);
    chk(row_valid == '0, "R9 dropped", 128'(row_valid), 0);
    chk(row_err == 1'b1, "R9 flag", 128'(row_err), 1);
    @(negedge clk);
    chk(row_err == 1'b1, "R9 sticky", 128'(row_err), 1);
  endtask

  task automatic t_decomp;
    decomp_en = 1'b1;
    send(hdr(8'h00, 5'd4, 6'h01), 32'h5, 32'h6, 32'h7);
    chk(row_valid == '0, "R10 discarded", 128'(row_valid), 0);
    decomp_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_bulk;
    send(hdr(8'h80, 5'd9, 6'h02), 32'd25, 32'h0, 32'h0);
    chk(row_valid == '0, "R5 load no delivery", 128'(row_valid), 0);
    chk(frame_cnt == 32'd25, "R5 count loaded", 128'(frame_cnt), 25);
    chk(cnt_err == 1'b0, "R7 multiple ok", 128'(cnt_err), 0);
    decomp_en = 1'b1;
    send(hdr(8'h00, 5'd3, 6'h11), 32'h1, 32'h2, 32'h3);
    chk(row_valid == '0 && frame_cnt == 32'd25, "R10 bulk count kept",
        128'(frame_cnt), 25);
    decomp_en = 1'b0;
    for (int k = 0; k < 25; k++) begin
      logic [31:0] a, b, c, d;
      a = hdr(8'h00, 5'd3, 6'h11); b = 32'h1000 + 32'(k);
      c = 32'h2000 + 32'(k);       d = 32'h3000 + 32'(k);
      send(a, b, c, d);
      chk(row_valid == NR'(1 << 9), "R6 latched row", 128'(row_valid), 128'(1 << 9));
      chk(row_reg == 6'h02 && row_data == {d, c, b, a}, "R6 raw quadword",
          row_data, {d, c, b, a});
      chk(frame_cnt == 32'(24 - k), "R6 decrement", 128'(frame_cnt), 128'(24 - k));
    end
    send(hdr(8'h00, 5'd3, 6'h11), 32'h1, 32'h2, 32'h3);
    chk(row_valid == NR'(1 << 3) && row_reg == 6'h11, "R6 header mode resumes",
        128'(row_valid), 128'(1 << 3));
    @(negedge clk);
  endtask

  task automatic t_loaderr;
    send(hdr(8'h80, 5'd31, 6'h02), 32'd3, 32'h0, 32'h0);
    chk(cnt_err == 1'b1, "R7 flag", 128'(cnt_err), 1);
    chk(frame_cnt == 32'd3, "R7 load kept", 128'(frame_cnt), 3);
    for (int k = 0; k < 3; k++) begin
      send(32'h0, 32'h1, 32'h2, 32'h3);
      chk(row_valid == {NR{1'b1}}, "R7 R8 bulk broadcast", 128'(row_valid),
          128'({NR{1'b1}}));
    end
    chk(frame_cnt == '0 && cnt_err == 1'b1, "R7 drained, flag sticky",
        128'(frame_cnt), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; decomp_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame();
    t_clear();
    t_bcast();
    t_other();
    t_decomp();
    t_bulk();
    t_badrow();
    t_loaderr();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule